// File: doc/BRIEF.md
# Channel Queue Index Registers

This block holds the four index registers of one transfer channel. The channel has two circular queues of fixed-size elements in host memory. The host posts work into the request queue. The device posts completions into the response queue. The host reaches the indexes through a small 32-bit register bus. The device side uses single-cycle strobes: one to say it consumed a request element and one to say it produced a response element.

The block also turns each queue index into a byte address, computed as base plus index times element size, so the device knows where to fetch the next request and where to store the next response. It raises a one-cycle interrupt pulse when a response lands in a response queue that was empty. Further completions add no interrupts while the host has not yet drained the queue. The one exception is a completion whose force flag is set while the channel's force enable is on.

Top module: `qptr_chan_regs`

## Requirements
- R1: After reset all four indexes read 0, and `irq`, `req_pending` and `rsp_full` are low.
- R2: `reg_rdata` is combinational and is selected by `reg_addr[3:2]`: 0 gives request head, 1 gives request tail, 2 gives response head, 3 gives response tail. Each value is zero-extended to 32 bits. `reg_addr[1:0]` is ignored.
- R3: A write (`reg_wr_en`) with select 1 loads the request tail, and a write with select 2 loads the response head. Either takes `reg_wdata` modulo DEPTH and is visible on the next cycle. Writes with select 0 or 3 change nothing.
- R4: `req_pending` is high exactly when request head differs from request tail. `req_pop` advances the request head by one only while `req_pending` is high, and is otherwise ignored.
- R5: `rsp_full` is high when response tail plus one (mod DEPTH) equals response head. `rsp_push` advances the response tail by one only while `rsp_full` is low, and is otherwise ignored.
- R6: `req_elem_addr` equals `req_base` + request head × REQ_ELEM_BYTES. `rsp_elem_addr` equals `rsp_base` + response tail × RSP_ELEM_BYTES.
- R7: An accepted `rsp_push` made while the response queue is empty (head equals tail) gives `irq` high for exactly the next cycle.
- R8: An accepted push into a non-empty response queue gives no `irq` unless `rsp_force_irq` and `force_irq_en` are both high in that cycle. `rsp_force_irq` has no effect while `force_irq_en` is low.
- R9: All indexes wrap from DEPTH-1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| req_base | input | ADDR_W | Byte address of request queue element 0 |
| rsp_base | input | ADDR_W | Byte address of response queue element 0 |
| force_irq_en | input | 1 | Allows per-completion forced interrupts |
| req_pending | output | 1 | Request queue holds unconsumed elements |
| req_pop | input | 1 | Device consumed the element at request head |
| req_elem_addr | output | ADDR_W | Address of the next request element |
| rsp_push | input | 1 | Device wrote a response element at response tail |
| rsp_force_irq | input | 1 | Force flag of the completing request |
| rsp_full | output | 1 | Response queue cannot take another element |
| rsp_elem_addr | output | ADDR_W | Address for the next response element |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The bench builds the block with DEPTH=8, 64-byte request elements and 4-byte response elements. At that depth, filling the response queue, hitting the full stall and wrapping every index all take only a handful of strobes. The power-of-two element sizes select the shift form of the address generator. A directed pass covers the read-only writes, the ignored pops and pushes, and each interrupt case, and a long random pass follows it. Every output is compared on every cycle against a behavioural model of the two queues.

// File: rtl/qptr_pkg.sv
`timescale 1ns/1ps
package qptr_pkg;
    typedef enum logic [1:0] {
        QSEL_RQ_HEAD = 2'd0,
        QSEL_RQ_TAIL = 2'd1,
        QSEL_RS_HEAD = 2'd2,
        QSEL_RS_TAIL = 2'd3
    } qsel_e;

    localparam int REG_W = 32;
endpackage

// File: rtl/qptr_ring.sv
`timescale 1ns/1ps
// Head/tail index pair of one circular queue. One side is host-loaded,
// the other is advanced by the device.
module qptr_ring #(
    parameter int IDX_W          = 8,
    parameter bit HOST_OWNS_TAIL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_we,
    input  logic [IDX_W-1:0] host_wdata,
    input  logic             dev_adv,
    output logic [IDX_W-1:0] head_o,
    output logic [IDX_W-1:0] tail_o,
    output logic             empty_o,
    output logic             full_o,
    output logic             adv_ok_o
);
    localparam logic [IDX_W-1:0] ONE = IDX_W'(1);

    typedef struct packed {
        logic [IDX_W-1:0] head;
        logic [IDX_W-1:0] tail;
    } ring_t;

    ring_t st_d, st_q;
    logic  empty, full, adv_ok;

    always_comb begin
        empty = (st_q.head == st_q.tail);
        full  = ((st_q.tail + ONE) == st_q.head);
    end

    generate
        if (HOST_OWNS_TAIL) begin : g_host_tail
            always_comb begin
                st_d      = st_q;
                adv_ok    = dev_adv && !empty;
                if (adv_ok)  st_d.head = st_q.head + ONE;
                if (host_we) st_d.tail = host_wdata;
            end
        end else begin : g_host_head
            always_comb begin
                st_d      = st_q;
                adv_ok    = dev_adv && !full;
                if (adv_ok)  st_d.tail = st_q.tail + ONE;
                if (host_we) st_d.head = host_wdata;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head_o   = st_q.head;
    assign tail_o   = st_q.tail;
    assign empty_o  = empty;
    assign full_o   = full;
    assign adv_ok_o = adv_ok;

    logic [IDX_W-1:0] dev_ptr, host_ptr;
    assign dev_ptr  = HOST_OWNS_TAIL ? st_q.head : st_q.tail;
    assign host_ptr = HOST_OWNS_TAIL ? st_q.tail : st_q.head;

    // R4 R5
    blocked_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_adv && !adv_ok) |=> $stable(dev_ptr));

    // R9
    adv_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv_ok |=> (dev_ptr == $past(dev_ptr) + ONE));

    // R3
    host_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_we |=> (host_ptr == $past(host_wdata)));
endmodule

// File: rtl/qptr_irq.sv
`timescale 1ns/1ps
// Interrupt coalescing: pulse on empty-to-non-empty, or on an enabled force.
module qptr_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic push_ok,
    input  logic was_empty,
    input  logic force_req,
    input  logic force_en,
    output logic irq_o
);
    typedef struct packed {
        logic irq;
    } irq_st_t;

    irq_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = push_ok && (was_empty || (force_req && force_en));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o = st_q.irq;

    // R7
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(push_ok));

    // R7
    empty_push_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_ok && was_empty) |=> irq_o);

    // R8
    coalesced_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_ok && !was_empty && !(force_req && force_en)) |=> !irq_o);
endmodule

// File: rtl/qptr_addr.sv
`timescale 1ns/1ps
// Element address = base + index * element size.
module qptr_addr #(
    parameter int ADDR_W     = 64,
    parameter int IDX_W      = 8,
    parameter int ELEM_BYTES = 64
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] addr_o
);
    localparam bit IS_POW2 = (ELEM_BYTES & (ELEM_BYTES - 1)) == 0;
    localparam int SHIFT   = $clog2(ELEM_BYTES);

    logic [ADDR_W-1:0] offset;

    generate
        if (IS_POW2) begin : g_shift
            assign offset = ADDR_W'(idx) << SHIFT;
        end else begin : g_mul
            assign offset = ADDR_W'(idx) * ADDR_W'(ELEM_BYTES);
        end
    endgenerate

    assign addr_o = base + offset;
endmodule

// File: rtl/qptr_chan_regs.sv
`timescale 1ns/1ps
module qptr_chan_regs
    import qptr_pkg::*;
#(
    parameter int DEPTH          = 256,
    parameter int ADDR_W         = 64,
    parameter int REQ_ELEM_BYTES = 64,
    parameter int RSP_ELEM_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [3:0]        reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic [ADDR_W-1:0] req_base,
    input  logic [ADDR_W-1:0] rsp_base,
    input  logic              force_irq_en,
    output logic              req_pending,
    input  logic              req_pop,
    output logic [ADDR_W-1:0] req_elem_addr,
    input  logic              rsp_push,
    input  logic              rsp_force_irq,
    output logic              rsp_full,
    output logic [ADDR_W-1:0] rsp_elem_addr,
    output logic              irq
);
    localparam int IDX_W = $clog2(DEPTH);

    qsel_e            sel;
    logic             wr_rq_tail, wr_rs_head;
    logic [IDX_W-1:0] rq_head, rq_tail, rs_head, rs_tail;
    logic             rq_empty, rq_full_unused, rq_adv_ok;
    logic             rs_empty, rs_full, rs_adv_ok;
    logic             unused_bits;

    assign unused_bits = ^{reg_addr[1:0], reg_wdata[REG_W-1:IDX_W], rq_full_unused};

    always_comb begin
        sel        = qsel_e'(reg_addr[3:2]);
        wr_rq_tail = reg_wr_en && (sel == QSEL_RQ_TAIL);
        wr_rs_head = reg_wr_en && (sel == QSEL_RS_HEAD);
        case (sel)
            QSEL_RQ_HEAD: reg_rdata = REG_W'(rq_head);
            QSEL_RQ_TAIL: reg_rdata = REG_W'(rq_tail);
            QSEL_RS_HEAD: reg_rdata = REG_W'(rs_head);
            QSEL_RS_TAIL: reg_rdata = REG_W'(rs_tail);
            default:      reg_rdata = '0;
        endcase
    end

    qptr_ring #(.IDX_W(IDX_W), .HOST_OWNS_TAIL(1'b1)) u_req_ring (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (wr_rq_tail),
        .host_wdata (reg_wdata[IDX_W-1:0]),
        .dev_adv    (req_pop),
        .head_o     (rq_head),
        .tail_o     (rq_tail),
        .empty_o    (rq_empty),
        .full_o     (rq_full_unused),
        .adv_ok_o   (rq_adv_ok)
    );

    qptr_ring #(.IDX_W(IDX_W), .HOST_OWNS_TAIL(1'b0)) u_rsp_ring (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (wr_rs_head),
        .host_wdata (reg_wdata[IDX_W-1:0]),
        .dev_adv    (rsp_push),
        .head_o     (rs_head),
        .tail_o     (rs_tail),
        .empty_o    (rs_empty),
        .full_o     (rs_full),
        .adv_ok_o   (rs_adv_ok)
    );

    qptr_addr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .ELEM_BYTES(REQ_ELEM_BYTES)) u_req_addr (
        .base   (req_base),
        .idx    (rq_head),
        .addr_o (req_elem_addr)
    );

    qptr_addr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .ELEM_BYTES(RSP_ELEM_BYTES)) u_rsp_addr (
        .base   (rsp_base),
        .idx    (rs_tail),
        .addr_o (rsp_elem_addr)
    );

    qptr_irq u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_ok   (rs_adv_ok),
        .was_empty (rs_empty),
        .force_req (rsp_force_irq),
        .force_en  (force_irq_en),
        .irq_o     (irq)
    );

    assign req_pending = !rq_empty;
    assign rsp_full    = rs_full;

    // R4
    idle_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_pop && !req_pending) |=> !irq || $past(rsp_push));

    // R5
    full_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_push && rsp_full) |=> !irq);
endmodule

// File: tb/test_qptr_chan_regs.sv
`timescale 1ns/1ps
module test_qptr_chan_regs;
    localparam int D  = 8;
    localparam int AW = 64;
    localparam int RQ_SZ = 64;
    localparam int RS_SZ = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr_en = 1'b0;
    logic [3:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [AW-1:0] req_base = 64'h0000_00AB_0000_1000;
    logic [AW-1:0] rsp_base = 64'h0000_00CD_0002_0000;
    logic          force_irq_en = 1'b0;
    logic          req_pending;
    logic          req_pop = 1'b0;
    logic [AW-1:0] req_elem_addr;
    logic          rsp_push = 1'b0;
    logic          rsp_force_irq = 1'b0;
    logic          rsp_full;
    logic [AW-1:0] rsp_elem_addr;
    logic          irq;

    always #2 clk = ~clk;

    qptr_chan_regs #(.DEPTH(D), .ADDR_W(AW), .REQ_ELEM_BYTES(RQ_SZ), .RSP_ELEM_BYTES(RS_SZ))
    i_qptr_chan_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_base(req_base),
        .rsp_base(rsp_base), .force_irq_en(force_irq_en), .req_pending(req_pending),
        .req_pop(req_pop), .req_elem_addr(req_elem_addr), .rsp_push(rsp_push),
        .rsp_force_irq(rsp_force_irq), .rsp_full(rsp_full),
        .rsp_elem_addr(rsp_elem_addr), .irq(irq)
    );

    int    errors = 0;
    int    checks = 0;
    string phase  = "R1 reset";

    // reference model
    int m_rqh = 0, m_rqt = 0, m_rsh = 0, m_rst = 0;
    bit m_irq = 1'b0;

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s phase=%s act=%0h exp=%0h", tag, phase, act, exp);
        end
    endtask

    task automatic model_update();
        bit empty, full, acc;
        empty = (m_rsh == m_rst);
        full  = (((m_rst + 1) % D) == m_rsh);
        acc   = rsp_push && !full;
        m_irq = acc && (empty || (rsp_force_irq && force_irq_en));
        if (req_pop && (m_rqh != m_rqt)) m_rqh = (m_rqh + 1) % D;
        if (acc) m_rst = (m_rst + 1) % D;
        if (reg_wr_en && reg_addr[3:2] == 2'd1) m_rqt = int'(reg_wdata % D);
        if (reg_wr_en && reg_addr[3:2] == 2'd2) m_rsh = int'(reg_wdata % D);
    endtask

    task automatic compare();
        logic [31:0] exp_rd;
        case (reg_addr[3:2])
            2'd0: exp_rd = 32'(m_rqh);
            2'd1: exp_rd = 32'(m_rqt);
            2'd2: exp_rd = 32'(m_rsh);
            default: exp_rd = 32'(m_rst);
        endcase
        chk("R2 rdata", 64'(reg_rdata), 64'(exp_rd));
        chk("R4 req_pending", 64'(req_pending), 64'(m_rqh != m_rqt));
        chk("R5 rsp_full", 64'(rsp_full), 64'(((m_rst + 1) % D) == m_rsh));
        chk("R6 req_elem_addr", req_elem_addr, req_base + 64'(m_rqh) * RQ_SZ);
        chk("R6 rsp_elem_addr", rsp_elem_addr, rsp_base + 64'(m_rst) * RS_SZ);
        chk("R7 R8 irq", 64'(irq), 64'(m_irq));
    endtask

    task automatic step();
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare();
    endtask

    task automatic drive(bit we, logic [3:0] a, logic [31:0] wd, bit pop, bit push, bit frc);
        reg_wr_en = we; reg_addr = a; reg_wdata = wd;
        req_pop = pop; rsp_push = push; rsp_force_irq = frc;
        step();
        reg_wr_en = 1'b0; req_pop = 1'b0; rsp_push = 1'b0; rsp_force_irq = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            reg_addr = 4'((i % 4) * 4 + (i % 3));
            step();
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: check outputs while held in reset are not compared; after release
        rst_n = 1'b1;
        compare();
        idle(4);

        phase = "R3 host write";
        drive(1'b1, 4'h4, 32'hFFFF_FFF5, 1'b0, 1'b0, 1'b0);  // tail = 5
        drive(1'b1, 4'h0, 32'h3, 1'b0, 1'b0, 1'b0);           // read-only, ignored
        drive(1'b1, 4'hC, 32'h6, 1'b0, 1'b0, 1'b0);           // read-only, ignored
        phase = "R2 readback";
        idle(8);
        drive(1'b0, 4'h7, 32'h0, 1'b0, 1'b0, 1'b0);

        phase = "R4 pop";
        repeat (7) drive(1'b0, 4'h0, 32'h0, 1'b1, 1'b0, 1'b0);
        drive(1'b1, 4'h4, 32'h7, 1'b1, 1'b0, 1'b0);          // pop on empty + tail write
        drive(1'b0, 4'h0, 32'h0, 1'b1, 1'b0, 1'b0);

        phase = "R5 R7 push";
        drive(1'b0, 4'hC, 32'h0, 1'b0, 1'b1, 1'b0);          // empty -> irq
        repeat (6) drive(1'b0, 4'hC, 32'h0, 1'b0, 1'b1, 1'b0);
        drive(1'b0, 4'hC, 32'h0, 1'b0, 1'b1, 1'b0);          // full, ignored
        idle(2);

        phase = "R8 force";
        drive(1'b1, 4'h8, 32'h6, 1'b0, 1'b0, 1'b0);
        drive(1'b0, 4'hC, 32'h0, 1'b0, 1'b1, 1'b1);          // force but disabled
        force_irq_en = 1'b1;
        drive(1'b0, 4'hC, 32'h0, 1'b0, 1'b1, 1'b1);          // forced irq
        drive(1'b0, 4'hC, 32'h0, 1'b0, 1'b1, 1'b0);          // coalesced
        idle(2);

        phase = "R9 wrap";
        drive(1'b1, 4'h8, 32'h2, 1'b0, 1'b0, 1'b0);          // response empty again
        drive(1'b0, 4'hC, 32'h0, 1'b0, 1'b1, 1'b0);          // irq
        drive(1'b1, 4'h4, 32'h1, 1'b0, 1'b0, 1'b0);
        repeat (4) drive(1'b0, 4'h0, 32'h0, 1'b1, 1'b0, 1'b0);
        idle(4);

        phase = "random R2 R4 R5 R7 R8 R9";
        for (int i = 0; i < 600; i++) begin
            force_irq_en = ($urandom % 2) == 0;
            drive(($urandom % 6) == 0, 4'($urandom), $urandom,
                  ($urandom % 2) == 0, ($urandom % 3) == 0, ($urandom % 4) == 0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog phase=%s act=running exp=done", phase);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule